// File: doc/BRIEF.md
# Clocked Three-Cycle Bus Read Master

This block issues memory reads on a clocked bus with separate address and data lines. A requester presents an address with a request. The block then runs a fixed access made of three bus cycles, T1, T2 and T3. It places the address on the bus at the start of T1. Half a bus cycle later it lowers the memory-request and read strobes together. It takes the returned data into its buffer register in the middle of T3, and it reports completion with a one-cycle pulse.

The block runs on `clk_i`, which is twice the bus rate. Each `clk_i` cycle is one half of a bus cycle. The block generates the bus clock itself as `bus_clk_o`, which toggles on every `clk_i` edge. A slow slave holds the active-low wait line low at the end of T2. Each such cycle inserts one extra bus cycle before T3.

Top module: `sync_read_master`

## Requirements
- R1: While `rst_ni` is low, `mreq_no` and `rd_no` are 1, `bus_addr_o` is 0, `done_o` is 0 and `bus_clk_o` is 0. Reset acts asynchronously, so strobes return high at once even in the middle of an access.
- R2: `bus_clk_o` inverts on every `clk_i` edge. `ready_o` is 1 only when the block is idle and `bus_clk_o` is 0. A request is taken at a `clk_i` edge where `req_i` and `ready_o` are both 1.
- R3: From the acceptance edge until the end of the high half of T3, `bus_addr_o` holds the accepted `addr_i`. Outside that window it is 0.
- R4: `mreq_no` and `rd_no` fall together at the start of the low half of T1, one `clk_i` cycle after the address appears. Without wait cycles they stay low for four `clk_i` cycles (two bus periods) and rise at the start of the low half of T3.
- R5: `bus_data_i` is sampled only at the `clk_i` edge that ends the high half of T3. `rdata_o` shows the sampled value from then on and holds it until the next access captures new data.
- R6: `done_o` is 1 for exactly one `clk_i` cycle, the low half of T3. With no wait, it is high during the fifth `clk_i` cycle after the acceptance edge.
- R7: `wait_ni` is sampled at the edge that ends the low half of T2, and at the edge that ends each inserted wait cycle. A 0 inserts one more bus cycle with strobes held low and the address stable. Each inserted cycle delays `done_o` by two `clk_i` cycles.
- R8: `req_i` and `addr_i` are ignored while an access is in progress. The bus address stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the bus rate; one cycle is one half of a bus cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request from the requester |
| addr_i | input | ADDR_W | Address for the read |
| ready_o | output | 1 | The block can accept a request at this edge |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Memory buffer register contents |
| bus_clk_o | output | 1 | Generated bus clock |
| bus_addr_o | output | ADDR_W | Bus address lines |
| mreq_no | output | 1 | Memory request strobe, active low |
| rd_no | output | 1 | Read strobe, active low |
| wait_ni | input | 1 | Wait request from the slave, active low |
| bus_data_i | input | DATA_W | Bus data lines |

## Verification
The slave model in the bench places valid data on the bus only during the high half of T3. If the sequencer runs one state early or late, `rdata_o` takes a garbage value, and `done_o` lands on the wrong cycle count. Either error is visible at the first completion.

If the phase or state register is corrupted, strobes show up in the bus-high half or while the address is 0. This is seen within one `clk_i` cycle of the strobe edge.

A wait decision read at the wrong edge moves `done_o` by a multiple of two cycles. This is caught on the first access that carries a wait.

// File: rtl/srm_pkg.sv
package srm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_T1H,
    ST_T1L,
    ST_T2H,
    ST_T2L,
    ST_TWH,
    ST_TWL,
    ST_T3H,
    ST_T3L
  } bus_st_e;
endpackage

// File: rtl/srm_seq.sv
module srm_seq
  import srm_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic    wait_ni,
  output logic    bus_clk_o,
  output logic    ready_o,
  output logic    accept_o,
  output logic    capture_o,
  output logic    strobe_o,
  output logic    done_o
);
  bus_st_e st_q, st_d;
  logic    ph_q;

  // free-running half-cycle phase; 1 = bus clock high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ~ph_q;
  end

  assign bus_clk_o = ph_q;
  assign ready_o   = (st_q == ST_IDLE) && !ph_q;
  assign accept_o  = ready_o && req_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept_o) st_d = ST_T1H;
      ST_T1H:  st_d = ST_T1L;
      ST_T1L:  st_d = ST_T2H;
      ST_T2H:  st_d = ST_T2L;
      ST_T2L:  st_d = wait_ni ? ST_T3H : ST_TWH;
      ST_TWH:  st_d = ST_TWL;
      ST_TWL:  st_d = wait_ni ? ST_T3H : ST_TWH;
      ST_T3H:  st_d = ST_T3L;
      ST_T3L:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign strobe_o  = (st_q == ST_T1L) || (st_q == ST_T2H) || (st_q == ST_T2L) ||
                     (st_q == ST_TWH) || (st_q == ST_TWL) || (st_q == ST_T3H);
  assign capture_o = (st_q == ST_T3H);
  assign done_o    = (st_q == ST_T3L);
endmodule

// File: rtl/srm_addr_reg.sv
module srm_addr_reg #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] ADDR_IDLE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              clear_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_o <= ADDR_IDLE;
    else if (load_i)  addr_o <= addr_i;
    else if (clear_i) addr_o <= ADDR_IDLE;
  end
endmodule

// File: rtl/srm_mbr.sv
module srm_mbr #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    data_o <= '0;
    else if (cap_i) data_o <= data_i;
  end
endmodule

// File: rtl/sync_read_master.sv
module sync_read_master #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bus_clk_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              mreq_no,
  output logic              rd_no,
  input  logic              wait_ni,
  input  logic [DATA_W-1:0] bus_data_i
);
  localparam logic [ADDR_W-1:0] ADDR_IDLE = '0;

  logic accept, capture, strobe;

  srm_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .wait_ni   (wait_ni),
    .bus_clk_o (bus_clk_o),
    .ready_o   (ready_o),
    .accept_o  (accept),
    .capture_o (capture),
    .strobe_o  (strobe),
    .done_o    (done_o)
  );

  srm_addr_reg #(.ADDR_W(ADDR_W), .ADDR_IDLE(ADDR_IDLE)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .clear_i (capture),
    .addr_i  (addr_i),
    .addr_o  (bus_addr_o)
  );

  srm_mbr #(.DATA_W(DATA_W)) u_mbr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (capture),
    .data_i (bus_data_i),
    .data_o (rdata_o)
  );

  assign mreq_no = ~strobe;
  assign rd_no   = ~strobe;
endmodule

// File: rtl/sync_read_master_chk.sv
module sync_read_master_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              done_o,
  input logic              bus_clk_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              mreq_no,
  input logic              rd_no
);
  assert_clk_toggle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_clk_o |=> !bus_clk_o);

  assert_strobes_paired_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreq_no == rd_no);

  assert_strobe_after_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mreq_no) |-> (!bus_clk_o && $stable(bus_addr_o) && bus_addr_o == $past(bus_addr_o)));

  assert_addr_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreq_no && $past(!mreq_no)) |-> $stable(bus_addr_o));

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (mreq_no && $past(!mreq_no)));

  assert_ready_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (mreq_no && !bus_clk_o));
endmodule

bind sync_read_master sync_read_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ready_o    (ready_o),
  .done_o     (done_o),
  .bus_clk_o  (bus_clk_o),
  .bus_addr_o (bus_addr_o),
  .mreq_no    (mreq_no),
  .rd_no      (rd_no)
);

// File: tb/sync_read_master_test.sv
`timescale 1ns/1ps
module sync_read_master_test;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam logic [DW-1:0] KEY = 16'h5A3C;
  localparam int NV = 6;
  // {address, wait cycles}
  localparam logic [19:0] VEC [NV] = '{
    {16'h1234, 4'd0}, {16'hFFFF, 4'd0}, {16'h0001, 4'd1},
    {16'h8000, 4'd2}, {16'hA5A5, 4'd0}, {16'h7E01, 4'd3}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, req_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic ready_o, done_o, bus_clk_o, mreq_no, rd_no, wait_ni;
  logic [DW-1:0] rdata_o, bus_data_i;
  logic [AW-1:0] bus_addr_o;
  int checks = 0, errors = 0, cur_nw = 0, scnt = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  sync_read_master uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i),
    .ready_o(ready_o), .done_o(done_o), .rdata_o(rdata_o),
    .bus_clk_o(bus_clk_o), .bus_addr_o(bus_addr_o), .mreq_no(mreq_no),
    .rd_no(rd_no), .wait_ni(wait_ni), .bus_data_i(bus_data_i)
  );

  // slave: counts strobed half-cycles; data valid only in T3 high half
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      scnt <= 0;
    else if (!mreq_no) scnt <= scnt + 1;
    else              scnt <= 0;
  end
  assign wait_ni    = !(!mreq_no && scnt < 2 + 2*cur_nw);
  assign bus_data_i = (!mreq_no && !rd_no && scnt == 3 + 2*cur_nw) ? (bus_addr_o ^ KEY) : 16'hFFFF;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_access(input logic [AW-1:0] a, input int nw, input bit busy_req);
    int cnt;
    cur_nw = nw;
    @(negedge clk_i);
    while (!ready_o) @(negedge clk_i);
    req_i = 1'b1; addr_i = a;
    @(negedge clk_i);                       // T1 high
    req_i = 1'b0; addr_i = ~a;
    chk(bus_addr_o == a, "R3 addr in T1", 32'(bus_addr_o), 32'(a));
    chk(mreq_no && rd_no && bus_clk_o, "R4 strobes high in T1 high", {mreq_no, rd_no, bus_clk_o}, 3'b111);
    @(negedge clk_i);                       // T1 low
    chk(!mreq_no && !rd_no, "R4 strobes low in T1 low", {mreq_no, rd_no}, 2'b00);
    if (busy_req) begin req_i = 1'b1; addr_i = 16'h0BAD; end
    cnt = 1;
    while (!done_o && cnt < 40) begin
      @(negedge clk_i);
      cnt++;
      if (busy_req && cnt == 3)
        chk(bus_addr_o == a, "R8 busy request ignored", 32'(bus_addr_o), 32'(a));
    end
    req_i = 1'b0;
    chk(cnt == 5 + 2*nw, nw == 0 ? "R6 done latency" : "R7 wait latency", 32'(cnt), 32'(5 + 2*nw));
    chk(rdata_o == (a ^ KEY), "R5 captured data", 32'(rdata_o), 32'(a ^ KEY));
    chk(bus_addr_o == '0 && mreq_no, "R3 addr released in T3 low", 32'(bus_addr_o), 32'h0);
    @(negedge clk_i);
    chk(!done_o, "R6 done one cycle", 32'(done_o), 32'h0);
    chk(rdata_o == (a ^ KEY), "R5 data held", 32'(rdata_o), 32'(a ^ KEY));
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #35;
    chk(mreq_no && rd_no && bus_addr_o == '0 && !done_o && !bus_clk_o,
        "R1 reset state", {mreq_no, rd_no, done_o, bus_clk_o}, 4'b1100);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk(bus_clk_o == 1'b1, "R2 bus clock toggles", 32'(bus_clk_o), 32'h1);
    @(negedge clk_i);
    chk(bus_clk_o == 1'b0 && ready_o, "R2 ready in low half", {bus_clk_o, ready_o}, 2'b01);

    for (int i = 0; i < NV; i++) run_access(VEC[i][19:4], int'(VEC[i][3:0]), 1'b0);

    run_access(16'h3C3C, 1, 1'b1);

    // R1: reset in the middle of an access
    cur_nw = 0;
    @(negedge clk_i);
    while (!ready_o) @(negedge clk_i);
    req_i = 1'b1; addr_i = 16'h4242;
    @(negedge clk_i); req_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b0; #1;
    chk(mreq_no && rd_no && bus_addr_o == '0, "R1 async reset mid access",
        {mreq_no, rd_no, 14'(bus_addr_o)}, 16'hC000);
    @(negedge clk_i); rst_ni = 1'b1;
    run_access(16'h0F0F, 0, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule